// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Sticky Flag

This unit holds five BCD alarm bytes (month, day, hour, minute, second) and compares them with a live BCD calendar supplied by an external timekeeping counter. The comparison is made only in the clock cycle that carries the one-second tick. When every field agrees, a sticky alarm flag is raised. The flag drives an active-low, level-type interrupt while the alarm enable bit is set. Software clears the flag by rewriting the flags byte with a 0 in the alarm-flag position, normally as a read-modify-write.

Software reaches the unit through a simple byte-wide port with a write strobe and a combinational read. Three control bits share the alarm bytes: the alarm enable and square-wave enable in the month byte, and a halt-update bit in the hour byte. The flags byte also carries a sticky oscillator-failure indication and the live battery-low input. The serial bus that carries these accesses and the time counter itself are outside this block.

The flag is owned by a two-state machine. In `ST_ARMED` the flag reads 0. The transition ARMED→FIRED is taken on a tick cycle with a full match. In `ST_FIRED` the flag reads 1. The transition FIRED→ARMED is taken on a flags write with bit 6 at 0, provided that a new match is not being set in the same cycle. In every other case each state holds.

Top module: `alm_unit`

## Requirements
- R1: After reset, every alarm byte reads 0x00, the flags byte reads 0x00 apart from the live battery-low bit (bit 4), irq_n is 1, and alarm_pend, sqw_en and halt_upd are 0.
- R2: A write to address 0x0A (month), 0x0B (day), 0x0C (hour), 0x0D (minute) or 0x0E (second) stores all 8 bits, and a read of the same address returns them in the same cycle the address is presented.
- R3: Writes to any address other than 0x0A–0x0F change no stored state, and reads of such addresses return 0x00.
- R4: On a clock with sec_tick high where the masked fields are all equal, the alarm flag (flags bit 6) reads 1 from the next cycle. The masks are month 0x3F, day 0x3F, hour 0x3F, minute 0x7F and second 0x7F, applied to both the alarm byte and the time byte.
- R5: The flag never rises on a cycle without sec_tick, even if the time matches, and it does not rise on a tick where any masked field differs.
- R6: Once set, the flag stays at 1 until a write to 0x0F with bit 6 equal to 0. Writing 0x0F with bit 6 equal to 1 leaves it unchanged.
- R7: If a matching tick and a flag-clearing write occur in the same cycle, the flag is 1 afterwards.
- R8: irq_n is 0 exactly while the flag is 1 and the enable bit (bit 7 of 0x0A) is 1. Clearing either bit releases it in the next cycle.
- R9: alarm_pend is 1 exactly when the flag and the enable bit are both 1.
- R10: sqw_en follows bit 6 of 0x0A and halt_upd follows bit 6 of 0x0C. Neither bit takes part in the comparison.
- R11: Flags bit 2 becomes 1 the cycle after osc_fail is high and stays at 1 until a write to 0x0F with bit 2 equal to 0; a new failure wins over a clear in the same cycle. Flags bit 4 reads batt_low directly. The other flags bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second from the time counter |
| tm_mon | input | 8 | Current month, BCD |
| tm_day | input | 8 | Current day of month, BCD |
| tm_hour | input | 8 | Current hour, BCD |
| tm_min | input | 8 | Current minute, BCD |
| tm_sec | input | 8 | Current second, BCD |
| osc_fail | input | 1 | Oscillator failure event |
| batt_low | input | 1 | Battery low level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_n | output | 1 | Active-low level interrupt |
| alarm_pend | output | 1 | Alarm flag set while enabled |
| sqw_en | output | 1 | Square-wave enable bit |
| halt_upd | output | 1 | Halt-update bit |

## Verification
The comparison is tried against times that match only after masking, where the enable, square-wave and halt bits are set in the alarm bytes. This shows that the control bits are kept out of the comparison. It is also tried against times where only one field differs, once for each of the five fields, which shows that every field takes part. A matching time held with no tick separates tick-qualified evaluation from continuous comparison. A clear that lands on the same cycle as a matching tick separates set-priority from clear-priority. Flag writes with bit 6 at 1 and at 0, and toggles of the enable bit, show that the interrupt is a level gated by the enable rather than a pulse.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
    localparam int NFLD      = 5;
    localparam int BW        = 8;
    localparam int ADR_BASE  = 10;
    localparam int ADR_FLAGS = 15;
    localparam int FLD_MON   = 0;
    localparam int FLD_HOUR  = 2;
    localparam int EN_BIT    = 7;
    localparam int SQ_BIT    = 6;
    localparam int HT_BIT    = 6;
    localparam int AF_BIT    = 6;
    localparam int OF_BIT    = 2;
    localparam int BL_BIT    = 4;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_FIRED = 1'b1
    } alm_st_e;

    // Comparison mask per field: month, day, hour use 6 bits; minute, second use 7
    function automatic logic [BW-1:0] fld_mask(input int idx);
        return (idx <= FLD_HOUR) ? 8'h3F : 8'h7F;
    endfunction
endpackage

// File: rtl/alm_regs.sv
`timescale 1ns/1ps
module alm_regs
    import alm_pkg::*;
#(
    parameter int AW = 8,
    parameter int NF = NFLD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [BW-1:0]          wdata,
    output logic [NF-1:0][BW-1:0]  alm,
    output logic                   en,
    output logic                   sqwe,
    output logic                   halt
);
    logic [NF-1:0][BW-1:0] alm_q;
    logic [NF-1:0]         sel;
    logic                  mapped;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_slot
            localparam logic [AW-1:0] SLOT_ADR = AW'(ADR_BASE + gi);
            assign sel[gi] = (addr == SLOT_ADR);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alm_q[gi] <= '0;
                end else if (we && sel[gi]) begin
                    alm_q[gi] <= wdata;
                end
            end
        end
    endgenerate

    assign mapped = (|sel) || (addr == AW'(ADR_FLAGS));
    assign alm    = alm_q;
    assign en     = alm_q[FLD_MON][EN_BIT];
    assign sqwe   = alm_q[FLD_MON][SQ_BIT];
    assign halt   = alm_q[FLD_HOUR][HT_BIT];

    // R3
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !mapped) |=> $stable(alm_q));
endmodule

// File: rtl/alm_match.sv
`timescale 1ns/1ps
module alm_match
    import alm_pkg::*;
#(
    parameter int NF = NFLD
) (
    input  logic [NF-1:0][BW-1:0] alm,
    input  logic [NF-1:0][BW-1:0] tm,
    output logic                  hit
);
    logic [NF-1:0] eq;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_cmp
            localparam logic [BW-1:0] MSK = fld_mask(gi);
            assign eq[gi] = ((alm[gi] ^ tm[gi]) & MSK) == '0;
        end
    endgenerate

    assign hit = &eq;
endmodule

// File: rtl/alm_flag_fsm.sv
`timescale 1ns/1ps
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    input  logic en,
    output logic af,
    output logic irq_n,
    output logic pend
);
    alm_st_e state_q, state_d;
    logic    set_ev;

    assign set_ev = tick && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (set_ev) state_d = ST_FIRED;
            ST_FIRED: if (clr && !set_ev) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        af    = (state_q == ST_FIRED);
        pend  = af && en;
        irq_n = !(af && en);
    end

    // R4
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit) |=> af);
    // R5
    tick_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!af && !tick) |=> !af);
    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (af && !clr) |=> af);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && clr) |=> af);
endmodule

// File: rtl/alm_unit.sv
`timescale 1ns/1ps
module alm_unit
    import alm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [7:0]    tm_mon,
    input  logic [7:0]    tm_day,
    input  logic [7:0]    tm_hour,
    input  logic [7:0]    tm_min,
    input  logic [7:0]    tm_sec,
    input  logic          osc_fail,
    input  logic          batt_low,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq_n,
    output logic          alarm_pend,
    output logic          sqw_en,
    output logic          halt_upd
);
    logic [NFLD-1:0][BW-1:0] alm_v;
    logic [NFLD-1:0][BW-1:0] tm_v;
    logic                    en_b;
    logic                    hit;
    logic                    flg_wr;
    logic                    clr_af;
    logic                    clr_of;
    logic                    af;
    logic                    of_q;

    assign tm_v = {tm_sec, tm_min, tm_hour, tm_day, tm_mon};

    assign flg_wr = reg_we && (reg_addr == AW'(ADR_FLAGS));
    assign clr_af = flg_wr && !reg_wdata[AF_BIT];
    assign clr_of = flg_wr && !reg_wdata[OF_BIT];

    alm_regs #(.AW(AW), .NF(NFLD)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .alm   (alm_v),
        .en    (en_b),
        .sqwe  (sqw_en),
        .halt  (halt_upd)
    );

    alm_match #(.NF(NFLD)) u_match (
        .alm (alm_v),
        .tm  (tm_v),
        .hit (hit)
    );

    alm_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .hit   (hit),
        .clr   (clr_af),
        .en    (en_b),
        .af    (af),
        .irq_n (irq_n),
        .pend  (alarm_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        of_q <= 1'b0;
        else if (osc_fail) of_q <= 1'b1;
        else if (clr_of)   of_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFLD; i++) begin
            if (reg_addr == AW'(ADR_BASE + i)) reg_rdata = alm_v[i];
        end
        if (reg_addr == AW'(ADR_FLAGS)) begin
            reg_rdata[AF_BIT] = af;
            reg_rdata[OF_BIT] = of_q;
            reg_rdata[BL_BIT] = batt_low;
        end
    end

    // R11
    of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (of_q && !clr_of) |=> of_q);
    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!af || !en_b) |-> irq_n);
endmodule

// File: tb/tb_alm_unit.sv
`timescale 1ns/1ps
module tb_alm_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] tm_mon = 8'h00, tm_day = 8'h00, tm_hour = 8'h00, tm_min = 8'h00, tm_sec = 8'h00;
    logic       osc_fail = 1'b0, batt_low = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n, alarm_pend, sqw_en, halt_upd;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    alm_unit #(.AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .tm_mon(tm_mon), .tm_day(tm_day), .tm_hour(tm_hour), .tm_min(tm_min), .tm_sec(tm_sec),
        .osc_fail(osc_fail), .batt_low(batt_low),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .alarm_pend(alarm_pend), .sqw_en(sqw_en), .halt_upd(halt_upd)
    );

    // Behavioural reference model
    logic [7:0] m_alm [5];
    logic       m_af, m_of, m_hit, m_clr_af, m_clr_of;
    logic [7:0] m_tv [5];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) m_alm[i] = 8'h00;
            m_af = 1'b0;
            m_of = 1'b0;
        end else begin
            m_tv[0] = tm_mon; m_tv[1] = tm_day; m_tv[2] = tm_hour; m_tv[3] = tm_min; m_tv[4] = tm_sec;
            m_hit = 1'b1;
            for (int i = 0; i < 5; i++) begin
                if ((m_alm[i] & ((i < 3) ? 8'h3F : 8'h7F)) != (m_tv[i] & ((i < 3) ? 8'h3F : 8'h7F)))
                    m_hit = 1'b0;
            end
            m_clr_af = reg_we && reg_addr == 8'h0F && !reg_wdata[6];
            m_clr_of = reg_we && reg_addr == 8'h0F && !reg_wdata[2];
            if (sec_tick && m_hit) m_af = 1'b1;
            else if (m_clr_af)     m_af = 1'b0;
            if (osc_fail)          m_of = 1'b1;
            else if (m_clr_of)     m_of = 1'b0;
            if (reg_we && reg_addr >= 8'h0A && reg_addr <= 8'h0E)
                m_alm[reg_addr - 8'h0A] = reg_wdata;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a >= 8'h0A && a <= 8'h0E) return m_alm[a - 8'h0A];
        if (a == 8'h0F) return {1'b0, m_af, 1'b0, batt_low, 1'b0, m_of, 2'b00};
        return 8'h00;
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", phase, what, got, exp, $time);
        end
    endtask

    // Compare on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk({7'd0, irq_n},      {7'd0, !(m_af && m_alm[0][7])}, "irq_n (R8)");
            chk({7'd0, alarm_pend}, {7'd0, m_af && m_alm[0][7]},    "alarm_pend (R9)");
            chk({7'd0, sqw_en},     {7'd0, m_alm[0][6]},            "sqw_en (R10)");
            chk({7'd0, halt_upd},   {7'd0, m_alm[2][6]},            "halt_upd (R10)");
            chk(reg_rdata, exp_rd(reg_addr), $sformatf("rdata@%h", reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); reg_addr = a;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] mo, dy, hr, mi, se);
        @(negedge clk);
        tm_mon = mo; tm_day = dy; tm_hour = hr; tm_min = mi; tm_sec = se;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        phase = "R1";
        @(negedge clk);
        chk({7'd0, irq_n}, 8'h01, "reset irq_n (R1)");
        for (int a = 8'h0A; a <= 8'h0F; a++) rd(8'(a));

        // R2 storage and readback; control bits set in month and hour
        phase = "R2";
        wr(8'h0A, 8'h45);
        wr(8'h0B, 8'h17);
        wr(8'h0C, 8'h43);
        wr(8'h0D, 8'h59);
        wr(8'h0E, 8'h30);
        for (int a = 8'h0A; a <= 8'h0E; a++) rd(8'(a));

        // R3 unmapped addresses
        phase = "R3";
        wr(8'h10, 8'hFF);
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'hAA);
        rd(8'h10); rd(8'h09); rd(8'h00); rd(8'hFF);
        for (int a = 8'h0A; a <= 8'h0E; a++) rd(8'(a));

        // R5 matching time held without tick
        phase = "R5";
        set_time(8'h05, 8'h17, 8'h03, 8'h59, 8'h30);
        reg_addr = 8'h0F;
        repeat (6) @(negedge clk);

        // R4 tick with masked match (sqw and halt bits in alarm bytes); R10
        phase = "R4";
        tick();
        rd(8'h0F);

        // R8 enable afterwards asserts the level
        phase = "R8";
        wr(8'h0A, 8'hC5);
        rd(8'h0F);
        repeat (3) @(negedge clk);

        // R6 writing 1 to bit 6 keeps the flag, 0 clears it
        phase = "R6";
        wr(8'h0F, 8'hFF);
        rd(8'h0F);
        wr(8'h0F, 8'hBF);
        rd(8'h0F);

        // R5 single-field mismatches on tick
        phase = "R5";
        set_time(8'h06, 8'h17, 8'h03, 8'h59, 8'h30); tick();
        set_time(8'h05, 8'h18, 8'h03, 8'h59, 8'h30); tick();
        set_time(8'h05, 8'h17, 8'h04, 8'h59, 8'h30); tick();
        set_time(8'h05, 8'h17, 8'h03, 8'h58, 8'h30); tick();
        set_time(8'h05, 8'h17, 8'h03, 8'h59, 8'h31); tick();
        rd(8'h0F);

        // R4 time bytes carrying upper bits that are masked off
        phase = "R4";
        set_time(8'hC5, 8'hD7, 8'hC3, 8'hD9, 8'hB0); tick();
        rd(8'h0F);

        // R7 clear and matching tick in same cycle
        phase = "R7";
        @(negedge clk);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h0F; reg_wdata = 8'hBF;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        rd(8'h0F);

        // R8 disable releases irq, flag stays
        phase = "R8";
        wr(8'h0A, 8'h05);
        rd(8'h0F);
        wr(8'h0A, 8'h85);
        wr(8'h0F, 8'h00);
        rd(8'h0F);

        // R9 pending only with both bits
        phase = "R9";
        set_time(8'h05, 8'h17, 8'h03, 8'h59, 8'h30); tick();
        wr(8'h0A, 8'h45);
        wr(8'h0A, 8'h85);
        wr(8'h0F, 8'h40);

        // R10 square-wave and halt bits alone
        phase = "R10";
        wr(8'h0A, 8'h40);
        wr(8'h0C, 8'h00);
        wr(8'h0C, 8'h40);

        // R11 oscillator failure and battery low
        phase = "R11";
        @(negedge clk); osc_fail = 1'b1;
        @(negedge clk); osc_fail = 1'b0;
        rd(8'h0F);
        wr(8'h0F, 8'hFF);
        batt_low = 1'b1;
        rd(8'h0F);
        @(negedge clk);
        osc_fail = 1'b1; reg_we = 1'b1; reg_addr = 8'h0F; reg_wdata = 8'h00;
        @(negedge clk);
        osc_fail = 1'b0; reg_we = 1'b0;
        rd(8'h0F);
        wr(8'h0F, 8'hFB);
        batt_low = 1'b0;
        rd(8'h0F);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule